// File: doc/BRIEF.md
# Serial CRC Engine with Selectable Bit Order

This block folds a serial bit stream into a cyclic redundancy check, one message bit per clock. A static mode input picks between two equivalent forms of the same arithmetic. In the left-shifting form the register moves toward its top bit and the generator is used as written. The caller feeds each byte most significant bit first. In the right-shifting form the register moves toward bit 0 and the generator is bit-reversed. The caller feeds each byte least significant bit first, and bits falling off the bottom are simply lost.

The generator, the start value and an output XOR mask are parameters, and the reversed generator is derived inside the block. A start strobe reloads the start value before each message. A valid strobe marks the cycles on which the data bit is absorbed. The check value is always visible on the output, one register stage after the last bit.

Top module: `crc_serial_engine`

## Requirements
- R1: While synchronous reset is high at a clock edge, the register loads START, so the output reads START ^ OUT_XOR (0xFFFF with defaults) on the following cycle.
- R2: A high start strobe loads START at the clock edge even when the valid strobe is also high; the data bit of that cycle is not absorbed.
- R3: With start and valid both low, the register keeps its value whatever the data bit does.
- R4: With mode input 0 (left form) and valid high, the feedback bit is the register's top bit XOR the data bit. The register shifts one place toward the top, the bit leaving the top is dropped, a 0 enters bit 0, and GEN is XORed in when the feedback bit is 1.
- R5: With mode input 1 (right form) and valid high, the feedback bit is register bit 0 XOR the data bit. The register shifts one place toward bit 0, a 0 enters the top, and the bit-reversal of GEN is XORed in when the feedback bit is 1.
- R6: With defaults (width 16, GEN 0x1021, START 0xFFFF, OUT_XOR 0), left form, the ASCII string "123456789" fed each byte top bit first yields 0x29B1.
- R7: With defaults, right form, the same string fed each byte bit 0 first yields 0x6F91.
- R8: For a symmetric START, the right-form result over a byte stream fed bit 0 first equals the 16-bit reversal of the left-form result over the same bytes, each byte bit-reversed and fed top bit first.
- R9: The output equals the register XOR the OUT_XOR parameter at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reflect_mode | input | 1 | 0 = left-shifting form, 1 = right-shifting form with reversed generator |
| start | input | 1 | Reload the register with START |
| bit_valid | input | 1 | Absorb bit_in on this edge |
| bit_in | input | 1 | Message bit |
| crc_out | output | WIDTH | Register value XOR OUT_XOR |

## Verification
The bench builds the block with its defaults: a 16-bit register, generator 0x1021, an all-ones start value that reads the same reversed, and a zero output mask. This brings the two published check values for "123456789" within reach, one for each bit order. It also makes the mirror relation between the two forms testable without any adjustment of the start value. Random messages with gaps in the valid strobe and start strobes landing on valid cycles run against a behavioural model on every clock.

// File: rtl/crc_serial_engine.sv
module crc_serial_engine #(
  parameter int WIDTH = 16,
  parameter logic [WIDTH-1:0] GEN = 16'h1021,
  parameter logic [WIDTH-1:0] START = 16'hFFFF,
  parameter logic [WIDTH-1:0] OUT_XOR = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reflect_mode,
  input  logic             start,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic [WIDTH-1:0] crc_out
);

  function automatic logic [WIDTH-1:0] mirror(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
    return r;
  endfunction

  localparam logic [WIDTH-1:0] GEN_REV = mirror(GEN);

  logic [WIDTH-1:0] crc_q;
  logic [WIDTH:0]   wide_left;
  logic [WIDTH-1:0] next_left, next_right;
  logic             fb_left, fb_right;

  assign fb_left    = crc_q[WIDTH-1] ^ bit_in;
  assign fb_right   = crc_q[0] ^ bit_in;
  assign wide_left  = {crc_q, 1'b0};
  assign next_left  = wide_left[WIDTH-1:0] ^ (fb_left ? GEN : '0);
  assign next_right = {1'b0, crc_q[WIDTH-1:1]} ^ (fb_right ? GEN_REV : '0);

  always_ff @(posedge clk) begin
    if (rst || start)  crc_q <= START;
    else if (bit_valid) crc_q <= reflect_mode ? next_right : next_left;
  end

  assign crc_out = crc_q ^ OUT_XOR;

  p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> crc_q == START);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!start && !bit_valid) |=> $stable(crc_q));

  p_left_zero_fill_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !start && !reflect_mode && (crc_q[WIDTH-1] == bit_in)) |=> !crc_q[0]);

  p_left_gen_lsb_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !start && !reflect_mode && (crc_q[WIDTH-1] != bit_in)) |=> crc_q[0] == GEN[0]);

  p_right_zero_fill_r5: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !start && reflect_mode && (crc_q[0] == bit_in)) |=> !crc_q[WIDTH-1]);

  p_right_gen_msb_r5: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !start && reflect_mode && (crc_q[0] != bit_in)) |=> crc_q[WIDTH-1] == GEN[0]);

  p_out_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (crc_out ^ crc_q) == OUT_XOR);

endmodule

// File: tb/crc_serial_engine_tb.sv
module crc_serial_engine_tb;
  localparam int W = 16;
  localparam int GEN = 'h1021;
  localparam int START = 'hFFFF;

  logic clk = 0, rst = 1, reflect_mode = 0, start = 0, bit_valid = 0, bit_in = 0;
  logic [W-1:0] crc_out;
  int checks = 0, fails = 0;
  int model = START;
  int gen_rev;

  always #2.5 clk = ~clk;

  crc_serial_engine u_dut (.clk(clk), .rst(rst), .reflect_mode(reflect_mode),
    .start(start), .bit_valid(bit_valid), .bit_in(bit_in), .crc_out(crc_out));

  function automatic int rev_bits(int v, int n);
    int r = 0;
    for (int i = 0; i < n; i++) if ((v >> i) & 1) r |= 1 << (n - 1 - i);
    return r;
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // one clock: drive at negedge, update model, compare after edge
  task automatic step(bit r, bit m, bit s, bit v, bit d, string req);
    @(negedge clk);
    rst = r; reflect_mode = m; start = s; bit_valid = v; bit_in = d;
    if (r || s) model = START;
    else if (v) begin
      if (!m) begin
        int fb = ((model >> (W - 1)) & 1) ^ d;
        model = (model * 2) % (1 << W);
        if (fb) model ^= GEN;
      end else begin
        int fb = (model & 1) ^ d;
        model = model / 2;
        if (fb) model ^= gen_rev;
      end
    end
    @(posedge clk); #1;
    check(req, crc_out, model);
  endtask

  task automatic byte_top_first(bit m, int b);
    for (int i = 7; i >= 0; i--) step(0, m, 0, 1, (b >> i) & 1, m ? "R5" : "R4");
  endtask

  task automatic byte_low_first(bit m, int b);
    for (int i = 0; i < 8; i++) step(0, m, 0, 1, (b >> i) & 1, m ? "R5" : "R4");
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    string msg = "123456789";
    byte unsigned bytes[$];
    int left_res;
    gen_rev = rev_bits(GEN, W);

    step(1, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 1, 1, "R1");
    check("R1", crc_out, 'hFFFF);
    check("R9", crc_out, model);

    // R6: known value, left form
    step(0, 0, 1, 0, 0, "R2");
    for (int k = 0; k < msg.len(); k++) byte_top_first(0, msg[k]);
    check("R6", crc_out, 'h29B1);

    // R7: known value, right form
    step(0, 1, 1, 0, 0, "R2");
    for (int k = 0; k < msg.len(); k++) byte_low_first(1, msg[k]);
    check("R7", crc_out, 'h6F91);

    // R3: idle cycles with toggling data hold the value
    for (int k = 0; k < 6; k++) step(0, k % 2, 0, 0, k % 2, "R3");
    check("R3", crc_out, 'h6F91);

    // R2: start wins over valid
    step(0, 0, 1, 1, 1, "R2");
    check("R2", crc_out, 'hFFFF);

    // random messages with gaps, both forms
    for (int t = 0; t < 40; t++) begin
      bit m = t % 2;
      step(0, m, 1, $urandom % 2, $urandom % 2, "R2");
      for (int k = 0; k < 64; k++) begin
        bit v = ($urandom % 4) != 0;
        step(0, m, 0, v, $urandom % 2, v ? (m ? "R5" : "R4") : "R3");
      end
    end

    // R8: mirror relation between the two forms
    for (int t = 0; t < 10; t++) begin
      bytes.delete();
      for (int k = 0; k < 6; k++) bytes.push_back($urandom % 256);
      step(0, 0, 1, 0, 0, "R2");
      foreach (bytes[k]) byte_top_first(0, rev_bits(bytes[k], 8));
      left_res = crc_out;
      step(0, 1, 1, 0, 0, "R2");
      foreach (bytes[k]) byte_low_first(1, bytes[k]);
      check("R8", crc_out, rev_bits(left_res, W));
    end

    // R1: reset in mid-message
    step(0, 0, 0, 1, 1, "R4");
    step(1, 0, 0, 1, 0, "R1");
    check("R1", crc_out, 'hFFFF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule